// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Normal and Fast Outputs

This block gathers up to 128 level-sensitive interrupt lines, organised as banks of 32, and reduces them to two request outputs: a normal request and a fast request. Every line carries a mask bit, a software-forced request bit and a level word. The level word holds a 6-bit priority and a routing bit that sends the line to one output or the other. A simple 32-bit register port gives software access to all of this state.

Each output has its own arbiter state machine with two named states. In `ARB_SORT` the arbiter watches its pending set and searches it every cycle. Transition *sort-to-hold*: on the first clock edge where any line is pending for that output, the winner's number is latched and the state moves to `ARB_HOLD`. The output is high only in `ARB_HOLD`, and the latched number stays frozen there. Transition *hold-to-sort*: on a write of the matching acknowledge bit, the arbiter returns to `ARB_SORT`. An acknowledge seen in `ARB_SORT` leaves the state unchanged. A soft reset forces both arbiters to `ARB_SORT`.

Line n sits in bank n/32 at bit n%32. Register offsets (byte addresses):
- 0x00: revision.
- 0x10: configuration. Bit 1 requests a soft reset.
- 0x14: status. Bit 0 reads 1 when no soft reset is in progress.
- 0x40: active normal-request number.
- 0x44: active fast-request number.
- 0x48: acknowledge. Bit 0 acknowledges the normal output; bit 1 acknowledges the fast output.
- Bank b occupies 0x80 + 0x20*b. Its word index r within that block selects:
  - r=0: raw inputs.
  - r=1: mask. Reads the mask; a write loads it directly.
  - r=2: write 1 to unmask. Reads the mask.
  - r=3: write 1 to mask. Reads the mask.
  - r=4: write 1 to force a software request. Reads the software bits.
  - r=5: write 1 to remove a software request. Reads the software bits.
  - r=6: pending for the normal output.
  - r=7: pending for the fast output.
- Line n's level word is at 0x100 + 4*n.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1, every level word reads 0, both outputs are low and the status word reads 1.
- R2: A 1 written at offset r=2 of a bank clears that mask bit. A 1 written at r=3 sets it. A 0 bit in either write leaves the mask bit unchanged.
- R3: The raw register (r=0) shows the hardware lines. A line's request is (hardware OR software) AND NOT mask. Pending-normal (r=6) is that request with routing bit 0, and pending-fast (r=7) is that request with routing bit 1. A masked line never asserts an output.
- R4: A single pending line n with routing 0 raises the normal output one clock after it becomes pending, and 0x40 reads n.
- R5: A line whose level word has bit 0 = 1 raises only the fast output, and 0x44 reads its number.
- R6: Among the pending lines of one output, the line with the numerically smallest priority (level bits 7:2) wins.
- R7: When pending lines tie on priority, the lowest line number wins.
- R8: While an output is high, its latched number does not change, even when a more urgent line becomes pending, until the matching acknowledge bit is written.
- R9: An acknowledge drops the output for at least one cycle. With nothing pending, the output stays low and the number register keeps its last value.
- R10: A 1 written at r=4 forces a request that is ORed with the hardware line. A 1 written at r=5 removes only the software part.
- R11: Writing bit 1 of 0x10 returns masks, level words, software bits and both arbiters to their reset values within two cycles.
- R12: A level word reads back as priority in bits 7:2, routing in bit 0, and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_BANKS*32 | Level-sensitive hardware interrupt lines |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets three kinds of mistake. The first is the bank and bit mapping: it sweeps every line number in turn, so a design that shifted by one bank or bit would report a wrong number or a wrong pending bit. The second is arbitration order: every line is given a distinct-looking priority that repeats every 64 lines, the lines are drained one by one, and a design that compared in the wrong direction or broke ties toward the higher index would pick a different line. The third is the frozen number and the idle acknowledge: a design that re-sorted while an output was held would switch to the urgent newcomer, and one that cleared the number on an idle acknowledge would read back a stale zero.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic {
        ARB_SORT = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    localparam logic [11:0] ADR_REV    = 12'h000;
    localparam logic [11:0] ADR_CFG    = 12'h010;
    localparam logic [11:0] ADR_STAT   = 12'h014;
    localparam logic [11:0] ADR_IRQNUM = 12'h040;
    localparam logic [11:0] ADR_FIQNUM = 12'h044;
    localparam logic [11:0] ADR_CTRL   = 12'h048;
    localparam logic [11:0] ADR_BANK   = 12'h080;
    localparam logic [11:0] ADR_LVL    = 12'h100;

    localparam int BANK_BITS   = 32;
    localparam int BANK_STRIDE = 32;

endpackage

// File: rtl/pic_pick.sv
module pic_pick #(
    parameter int LINES  = 96,
    parameter int PRIO_W = 6,
    parameter int NUM_W  = 7
) (
    input  logic [LINES-1:0]             pend,
    input  logic [LINES-1:0][PRIO_W-1:0] prio,
    output logic                         any,
    output logic [NUM_W-1:0]             win
);

    logic [PRIO_W-1:0] best;

    // Strict less-than while scanning upward keeps the lowest index on ties.
    always_comb begin
        any  = 1'b0;
        best = '1;
        win  = '0;
        for (int i = 0; i < LINES; i++) begin
            if (pend[i] && (!any || prio[i] < best)) begin
                any  = 1'b1;
                best = prio[i];
                win  = NUM_W'(i);
            end
        end
    end

endmodule

// File: rtl/pic_arb.sv
module pic_arb
    import pic_pkg::*;
#(
    parameter int NUM_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             any,
    input  logic [NUM_W-1:0] win,
    input  logic             ack,
    output logic             active,
    output logic [NUM_W-1:0] num
);

    arb_state_e st_q, st_d;
    logic [NUM_W-1:0] num_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= ARB_SORT;
        else if (clr) st_q <= ARB_SORT;
        else          st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_SORT: if (any) st_d = ARB_HOLD;
            ARB_HOLD: if (ack) st_d = ARB_SORT;
            default:  st_d = ARB_SORT;
        endcase
    end

    // outputs: latched winner is captured on the sort-to-hold transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      num_q <= '0;
        else if (clr)                    num_q <= '0;
        else if (st_q == ARB_SORT && any) num_q <= win;
    end

    assign active = (st_q == ARB_HOLD);
    assign num    = num_q;

endmodule

// File: rtl/pic_regs.sv
module pic_regs
    import pic_pkg::*;
#(
    parameter int          NUM_BANKS = 3,
    parameter int          PRIO_W    = 6,
    parameter int          NUM_W     = 7,
    parameter logic [7:0]  REV_ID    = 8'h12
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   clr,
    input  logic                                   we,
    input  logic [11:0]                            addr,
    input  logic [31:0]                            wdata,
    output logic [31:0]                            rdata,
    input  logic [NUM_BANKS*BANK_BITS-1:0]         raw,
    input  logic [NUM_W-1:0]                       irq_num,
    input  logic [NUM_W-1:0]                       fiq_num,
    output logic [NUM_BANKS*BANK_BITS-1:0]         mask,
    output logic [NUM_BANKS*BANK_BITS-1:0]         sw,
    output logic [NUM_BANKS*BANK_BITS-1:0]         irq_pend,
    output logic [NUM_BANKS*BANK_BITS-1:0]         fiq_pend,
    output logic [NUM_BANKS*BANK_BITS-1:0][PRIO_W-1:0] prio,
    output logic                                   ack_irq,
    output logic                                   ack_fiq,
    output logic                                   srst_req
);

    localparam int LINES = NUM_BANKS * BANK_BITS;

    logic [LINES-1:0] route;
    logic [LINES-1:0] req;
    logic             bank_hit, lvl_hit;
    logic [6:0]       bank_idx;
    logic [2:0]       bank_reg;
    logic [7:0]       lvl_idx;

    assign bank_hit = (addr >= ADR_BANK) && (addr < ADR_BANK + 12'(NUM_BANKS * BANK_STRIDE));
    assign bank_idx = 7'((addr - ADR_BANK) >> 5);
    assign bank_reg = addr[4:2];
    assign lvl_hit  = (addr >= ADR_LVL) && (addr < ADR_LVL + 12'(LINES * 4));
    assign lvl_idx  = 8'((addr - ADR_LVL) >> 2);

    assign ack_irq  = we && (addr == ADR_CTRL) && wdata[0];
    assign ack_fiq  = we && (addr == ADR_CTRL) && wdata[1];
    assign srst_req = we && (addr == ADR_CFG)  && wdata[1];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BANK_BITS-1:0] m_q, s_q;
        logic                 hit;
        assign hit = we && bank_hit && (bank_idx == 7'(b));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= '1;
                s_q <= '0;
            end else if (clr) begin
                m_q <= '1;
                s_q <= '0;
            end else if (hit) begin
                case (bank_reg)
                    3'd1:    m_q <= wdata;
                    3'd2:    m_q <= m_q & ~wdata;
                    3'd3:    m_q <= m_q | wdata;
                    3'd4:    s_q <= s_q | wdata;
                    3'd5:    s_q <= s_q & ~wdata;
                    default: ;
                endcase
            end
        end
        assign mask[b*BANK_BITS +: BANK_BITS] = m_q;
        assign sw[b*BANK_BITS +: BANK_BITS]   = s_q;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [PRIO_W-1:0] p_q;
        logic              r_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_q <= '0;
                r_q <= 1'b0;
            end else if (clr) begin
                p_q <= '0;
                r_q <= 1'b0;
            end else if (we && lvl_hit && lvl_idx == 8'(i)) begin
                p_q <= wdata[2 +: PRIO_W];
                r_q <= wdata[0];
            end
        end
        assign prio[i]  = p_q;
        assign route[i] = r_q;
    end

    assign req      = (raw | sw) & ~mask;
    assign irq_pend = req & ~route;
    assign fiq_pend = req & route;

    always_comb begin
        rdata = '0;
        if (bank_hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == 7'(b)) begin
                    case (bank_reg)
                        3'd0:          rdata = raw[b*BANK_BITS +: BANK_BITS];
                        3'd1, 3'd2, 3'd3: rdata = mask[b*BANK_BITS +: BANK_BITS];
                        3'd4, 3'd5:    rdata = sw[b*BANK_BITS +: BANK_BITS];
                        3'd6:          rdata = irq_pend[b*BANK_BITS +: BANK_BITS];
                        default:       rdata = fiq_pend[b*BANK_BITS +: BANK_BITS];
                    endcase
                end
            end
        end else if (lvl_hit) begin
            for (int i = 0; i < LINES; i++) begin
                if (lvl_idx == 8'(i))
                    rdata = {{(32-PRIO_W-2){1'b0}}, prio[i], 1'b0, route[i]};
            end
        end else begin
            case (addr)
                ADR_REV:    rdata = 32'(REV_ID);
                ADR_STAT:   rdata = {31'b0, ~clr};
                ADR_IRQNUM: rdata = 32'(irq_num);
                ADR_FIQNUM: rdata = 32'(fiq_num);
                default:    rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int         NUM_BANKS = 3,
    parameter int         PRIO_W    = 6,
    parameter logic [7:0] REV_ID    = 8'h12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_BANKS*32-1:0]       irq_lines,
    input  logic                          bus_we,
    input  logic [11:0]                   bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          irq_o,
    output logic                          fiq_o
);

    localparam int LINES = NUM_BANKS * BANK_BITS;
    localparam int NUM_W = $clog2(LINES);

    logic [LINES-1:0]             mask, sw, irq_pend, fiq_pend;
    logic [LINES-1:0][PRIO_W-1:0] prio;
    logic                         ack_irq, ack_fiq, srst_req, clr;
    logic                         irq_any, fiq_any;
    logic [NUM_W-1:0]             irq_win, fiq_win, irq_num, fiq_num;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr <= 1'b0;
        else        clr <= srst_req;
    end

    pic_regs #(
        .NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .REV_ID(REV_ID)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .raw(irq_lines), .irq_num(irq_num), .fiq_num(fiq_num),
        .mask(mask), .sw(sw), .irq_pend(irq_pend), .fiq_pend(fiq_pend),
        .prio(prio), .ack_irq(ack_irq), .ack_fiq(ack_fiq), .srst_req(srst_req)
    );

    pic_pick #(.LINES(LINES), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) i_pick_irq (
        .pend(irq_pend), .prio(prio), .any(irq_any), .win(irq_win)
    );

    pic_pick #(.LINES(LINES), .PRIO_W(PRIO_W), .NUM_W(NUM_W)) i_pick_fiq (
        .pend(fiq_pend), .prio(prio), .any(fiq_any), .win(fiq_win)
    );

    pic_arb #(.NUM_W(NUM_W)) i_arb_irq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .any(irq_any), .win(irq_win),
        .ack(ack_irq), .active(irq_o), .num(irq_num)
    );

    pic_arb #(.NUM_W(NUM_W)) i_arb_fiq (
        .clk(clk), .rst_n(rst_n), .clr(clr), .any(fiq_any), .win(fiq_win),
        .ack(ack_fiq), .active(fiq_o), .num(fiq_num)
    );

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int LINES = 96,
    parameter int NUM_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             we,
    input logic [11:0]      addr,
    input logic [31:0]      wdata,
    input logic             irq_o,
    input logic             fiq_o,
    input logic [NUM_W-1:0] irq_num,
    input logic [NUM_W-1:0] fiq_num,
    input logic [LINES-1:0] mask,
    input logic [LINES-1:0] sw,
    input logic [LINES-1:0] irq_pend,
    input logic [LINES-1:0] fiq_pend
);

    logic wr_ack_irq, wr_ack_fiq;
    assign wr_ack_irq = we && addr == 12'h048 && wdata[0];
    assign wr_ack_fiq = we && addr == 12'h048 && wdata[1];

    // R8
    irq_num_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (irq_o && !wr_ack_irq) |=> $stable(irq_num));

    // R8
    fiq_num_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (fiq_o && !wr_ack_fiq) |=> $stable(fiq_num));

    // R9
    irq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (irq_o && wr_ack_irq) |=> !irq_o);

    // R9
    fiq_ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (fiq_o && wr_ack_fiq) |=> !fiq_o);

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (we && addr == 12'h08C) |=> ((mask[31:0] & $past(wdata)) == $past(wdata)));

    // R2
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (we && addr == 12'h088) |=> ((mask[31:0] & $past(wdata)) == 32'h0));

    // R10
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (we && addr == 12'h094) |=> ((sw[31:0] & $past(wdata)) == 32'h0));

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(irq_o) |-> $past(|irq_pend));

    // R5
    fiq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(fiq_o) |-> $past(|fiq_pend));

endmodule

bind prio_irq_ctrl pic_chk #(.LINES(NUM_BANKS*32), .NUM_W(NUM_W)) u_pic_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .irq_o(irq_o), .fiq_o(fiq_o), .irq_num(irq_num),
    .fiq_num(fiq_num), .mask(mask), .sw(sw), .irq_pend(irq_pend),
    .fiq_pend(fiq_pend)
);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    localparam int NB    = 3;
    localparam int LINES = NB * 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] lines = '0;
    logic             we = 1'b0;
    logic [11:0]      addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    int pm [LINES];
    logic [LINES-1:0] pend_m;
    logic [31:0] v;
    int w;

    always #10 clk = ~clk;

    prio_irq_ctrl #(.NUM_BANKS(NB)) i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [11:0] breg(input int b, input int r);
        return 12'(128 + b * 32 + r * 4);
    endfunction

    function automatic logic [11:0] lreg(input int n);
        return 12'(256 + n * 4);
    endfunction

    function automatic int best(input logic [LINES-1:0] p);
        int bw = -1;
        for (int i = 0; i < LINES; i++)
            if (p[i] && (bw < 0 || pm[i] < pm[bw])) bw = i;
        return bw;
    endfunction

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        for (int i = 0; i < LINES; i++) pm[i] = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        for (int b = 0; b < NB; b++) begin
            rd(breg(b, 1), v); chk("R1 mask after reset", v, 32'hFFFF_FFFF);
        end
        rd(lreg(0), v);         chk("R1 level 0", v, 0);
        rd(lreg(LINES - 1), v); chk("R1 level last", v, 0);
        chk("R1 irq_o low", 32'(irq_o), 0);
        chk("R1 fiq_o low", 32'(fiq_o), 0);
        rd(12'h014, v);         chk("R1 status", v, 1);

        // R12 level word format
        wr(lreg(5), 32'hFFFF_FFFF);
        rd(lreg(5), v); chk("R12 level readback", v, 32'h0000_00FD);
        wr(lreg(5), 0);

        // R2 mask aliases
        wr(breg(1, 2), 32'h0000_F00F);
        rd(breg(1, 1), v); chk("R2 mask clear", v, 32'hFFFF_0FF0);
        wr(breg(1, 3), 32'h0000_0003);
        rd(breg(1, 1), v); chk("R2 mask set", v, 32'hFFFF_0FF3);
        wr(breg(1, 3), 32'h0);
        rd(breg(1, 2), v); chk("R2 zero write no change", v, 32'hFFFF_0FF3);

        // R3 raw and pending readouts
        lines[31:0] = 32'hA5A5_3C3C;
        step();
        rd(breg(0, 0), v); chk("R3 raw bank0", v, 32'hA5A5_3C3C);
        rd(breg(0, 6), v); chk("R3 masked pending", v, 0);
        chk("R3 masked no irq", 32'(irq_o), 0);
        for (int b = 0; b < NB; b++) wr(breg(b, 2), 32'hFFFF_FFFF);
        rd(breg(0, 6), v); chk("R3 pending irq bank0", v, 32'hA5A5_3C3C);
        rd(breg(0, 7), v); chk("R3 pending fiq bank0", v, 0);
        step();
        rd(12'h040, v); chk("R7 tie lowest of pattern", v, 2);
        lines = '0;
        wr(12'h048, 1);
        step();

        // R4 sweep every line
        for (int n = 0; n < LINES; n++) begin
            wr(breg(n / 32, 4), 32'(1) << (n % 32));
            step();
            chk("R4 irq_o high", 32'(irq_o), 1);
            rd(12'h040, v); chk("R4 number", v, 32'(n));
            rd(breg(n / 32, 6), v); chk("R4 pending bit", v, 32'(1) << (n % 32));
            wr(breg(n / 32, 5), 32'(1) << (n % 32));
            wr(12'h048, 1);
            chk("R9 irq_o drops after ack", 32'(irq_o), 0);
        end

        // R10 software OR hardware
        lines[7] = 1'b1;
        wr(breg(0, 4), 32'h80);
        wr(breg(0, 5), 32'h80);
        rd(breg(0, 4), v); chk("R10 sw bit cleared", v, 0);
        rd(breg(0, 6), v); chk("R10 hw keeps pending", v, 32'h80);
        lines[7] = 1'b0;
        step();
        rd(breg(0, 6), v); chk("R10 nothing pending", v, 0);
        wr(12'h048, 1);
        step();

        // R5 fast routing
        wr(lreg(40), (5 << 2) | 1);
        wr(breg(1, 4), 32'h100);
        step();
        chk("R5 fiq_o high", 32'(fiq_o), 1);
        chk("R5 irq_o low", 32'(irq_o), 0);
        rd(12'h044, v); chk("R5 fiq number", v, 40);
        rd(breg(1, 7), v); chk("R5 pending fiq", v, 32'h100);
        rd(breg(1, 6), v); chk("R5 pending irq empty", v, 0);
        wr(breg(1, 5), 32'h100);
        wr(12'h048, 2);
        chk("R5 fiq_o drops after ack", 32'(fiq_o), 0);
        wr(lreg(40), 0);

        // R6 priority drain, R7 ties among equal priorities
        for (int i = 0; i < LINES; i++) begin
            pm[i] = (i * 37 + 11) % 64;
            wr(lreg(i), 32'(pm[i] << 2));
        end
        pend_m = '1;
        for (int b = 0; b < NB; b++) wr(breg(b, 4), 32'hFFFF_FFFF);
        step();
        for (int k = 0; k < 20; k++) begin
            w = best(pend_m);
            rd(12'h040, v); chk("R6 R7 winner", v, 32'(w));
            chk("R6 irq_o held", 32'(irq_o), 1);
            wr(breg(w / 32, 5), 32'(1) << (w % 32));
            pend_m[w] = 1'b0;
            wr(12'h048, 1);
            step();
        end
        for (int b = 0; b < NB; b++) wr(breg(b, 5), 32'hFFFF_FFFF);
        wr(12'h048, 1);
        step();

        // R7 explicit tie, lines 5 and 69 share priority
        lines[5] = 1'b1; lines[69] = 1'b1;
        step();
        rd(12'h040, v); chk("R7 tie lower index", v, 5);
        lines = '0;
        wr(12'h048, 1);
        step();

        // R8 hold while a more urgent line arrives
        lines[60] = 1'b1;
        step();
        rd(12'h040, v); chk("R8 first winner", v, 60);
        lines[0] = 1'b1;
        step(); step();
        rd(12'h040, v); chk("R8 number frozen", v, 60);
        chk("R8 irq_o held", 32'(irq_o), 1);
        wr(12'h048, 1);
        step();
        rd(12'h040, v); chk("R8 urgent after ack", v, 32'(best(LINES'(1) | (LINES'(1) << 60))));
        lines[0] = 1'b0;
        wr(12'h048, 1);
        step();
        rd(12'h040, v); chk("R8 back to 60", v, 60);

        // R9 idle acknowledge
        lines = '0;
        wr(12'h048, 1);
        step();
        chk("R9 idle irq_o low", 32'(irq_o), 0);
        wr(12'h048, 1);
        step();
        chk("R9 second ack still low", 32'(irq_o), 0);
        rd(12'h040, v); chk("R9 number kept", v, 60);

        // R3 mask blocks a line
        wr(breg(0, 3), 32'h8);
        lines[3] = 1'b1;
        step(); step();
        chk("R3 masked line no irq", 32'(irq_o), 0);
        rd(breg(0, 6), v); chk("R3 masked not pending", v, 0);
        wr(breg(0, 2), 32'h8);
        step();
        chk("R3 unmask raises", 32'(irq_o), 1);
        rd(12'h040, v); chk("R3 unmasked number", v, 3);
        lines = '0;
        wr(12'h048, 1);
        step();

        // R11 soft reset
        wr(breg(2, 4), 32'h1);
        step();
        chk("R11 pre irq_o", 32'(irq_o), 1);
        wr(12'h010, 32'h2);
        step();
        chk("R11 irq_o cleared", 32'(irq_o), 0);
        rd(breg(0, 1), v); chk("R11 mask restored", v, 32'hFFFF_FFFF);
        rd(breg(2, 4), v); chk("R11 sw cleared", v, 0);
        rd(lreg(1), v);    chk("R11 level cleared", v, 0);
        rd(12'h040, v);    chk("R11 number cleared", v, 0);
        rd(12'h014, v);    chk("R11 status done", v, 1);

        finish_up();
    end

endmodule